// File: doc/BRIEF.md
# EEPROM Page-Write Buffer and Program Timer

This block sits behind the serial-bus protocol engine of a two-wire EEPROM model and owns the write path. Once the engine has received the word address of a write command, it loads that address into the block. Each acknowledged data byte is then handed over with a strobe. The block keeps the bytes in a page-sized staging buffer, with one valid flag per byte. The low address bits step through the page and wrap inside it, so one command can never cross a page boundary.

When the engine reports a STOP and all of the following hold, the block copies the flagged bytes into a synchronous array model: at least one whole byte was captured, no byte was half-received, and the write-protect pin is low. It then raises a busy flag for a parameterised number of clock cycles that stands for the self-timed programming interval. While busy is high, every request from the engine is ignored. A repeated START drops the staged bytes. A protected command is still acknowledged byte by byte but never programs.

A separate read port returns array contents one cycle after the address is presented. The write-protect pin has no effect on it.

Top module: `eeprom_page_writer`

## Requirements
- R1: Out of reset `busy_o` and `ack_o` are low.
- R2: After `load_i` with address A, the array address is `{page, offset}` with the offset in the low log2(PAGE_BYTES) bits. Data bytes land at offsets A, A+1, … modulo PAGE_BYTES in the same page. A later byte at an offset already filled replaces the earlier one.
- R3: A commit writes only the offsets that received a byte since the last `load_i`. Every other byte of the page keeps its previous contents.
- R4: A commit starts only on `stop_i` after a load with at least one byte and with `bit_pend_i` low. A STOP with no byte, a STOP with a byte in flight, or a byte or STOP without a preceding load starts nothing.
- R5: `busy_o` rises in the cycle after the committing STOP and stays high for exactly TWC_CYCLES cycles. While it is high, loads, bytes, STOPs and STARTs are ignored and `ack_o` stays low.
- R6: With `wp_i` high at STOP nothing is written and `busy_o` stays low. Data bytes of that command are still acknowledged.
- R7: `restart_i` discards the staged bytes, so a following STOP starts no write.
- R8: `rd_data_o` shows the array byte at `rd_addr_i` one cycle later, regardless of `wp_i`.
- R9: `ack_o` pulses one cycle after each byte strobe that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| load_i | input | 1 | Word address received; latch start address |
| load_addr_i | input | ADDR_W | Start address {page, offset} |
| byte_stb_i | input | 1 | One data byte completed on the bus |
| byte_i | input | DATA_W | Data byte |
| bit_pend_i | input | 1 | A byte is partly shifted in |
| stop_i | input | 1 | STOP seen on the bus |
| restart_i | input | 1 | Repeated START seen on the bus |
| wp_i | input | 1 | Write protect, high blocks programming |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, one cycle latency |
| ack_o | output | 1 | Byte accepted pulse |
| busy_o | output | 1 | Self-timed write interval in progress |

## Verification
The bench writes a full page and then overwrites part of it, with the start offset near the page end, so that the wrap shows. A design that carried into the page bits would corrupt the next page, and one that wrote the whole buffer would clobber bytes it never received. A seventeen-byte command checks that the last byte replaces the first at the same offset.

The bench also sends STOPs that must not program: after a restart, with a byte in flight, with no data, and with write protect high. A design that got any of these wrong would raise busy or change the page. During busy the bench injects a full write command; a design that failed to lock out the bus would acknowledge it or restage the buffer, and the read-back and the busy length would show it.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic {TS_IDLE = 1'b0, TS_RUN = 1'b1} tmr_state_e;

   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned OFS_W      = 4,
   parameter int unsigned PG_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              load_i,
   input  logic [PG_W-1:0]   load_pg_i,
   input  logic [OFS_W-1:0]  load_ofs_i,
   input  logic              byte_stb_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              bit_pend_i,
   input  logic              stop_i,
   input  logic              restart_i,
   input  logic              wp_i,
   input  logic [OFS_W-1:0]  sel_i,
   output logic [DATA_W-1:0] slot_o,
   output logic              slot_vld_o,
   output logic [PG_W-1:0]   page_o,
   output logic              go_o,
   output logic              ack_o
);

   logic              armed_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [PG_W-1:0]   page_q;
   logic              ack_q;
   logic              take;
   logic [DATA_W-1:0] slot_d [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] slot_v;

   assign take = !lock_i && armed_q && byte_stb_i;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [DATA_W-1:0] d_q;
      logic              v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (!lock_i && load_i) begin
            v_q <= 1'b0;
         end else if (take && (ofs_q == OFS_W'(g))) begin
            d_q <= byte_i;
            v_q <= 1'b1;
         end
      end
      assign slot_d[g] = d_q;
      assign slot_v[g] = v_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         ofs_q   <= '0;
         page_q  <= '0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= take;
         if (!lock_i) begin
            if (load_i) begin
               armed_q <= 1'b1;
               ofs_q   <= load_ofs_i;
               page_q  <= load_pg_i;
            end else if (stop_i || restart_i) begin
               armed_q <= 1'b0;
            end else if (take) begin
               ofs_q <= ofs_q + 1'b1;
            end
         end
      end
   end

   assign go_o       = !lock_i && stop_i && !restart_i && armed_q && (|slot_v)
                       && !bit_pend_i && !wp_i;
   assign slot_o     = slot_d[sel_i];
   assign slot_vld_o = slot_v[sel_i];
   assign page_o     = page_q;
   assign ack_o      = ack_q;

endmodule

// File: rtl/pw_write_timer.sv
module pw_write_timer #(
   parameter int unsigned TWC_CYCLES = 250000,
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned OFS_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   output logic             busy_o,
   output logic             walk_o,
   output logic [OFS_W-1:0] walk_idx_o
);
   import pw_pkg::*;

   localparam int unsigned CNT_W = cnt_w(TWC_CYCLES);

   tmr_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             walk_q;
   logic [OFS_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TS_IDLE;
         cnt_q  <= '0;
         walk_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         case (st_q)
            TS_IDLE: begin
               if (go_i) begin
                  st_q   <= TS_RUN;
                  cnt_q  <= CNT_W'(TWC_CYCLES - 1);
                  walk_q <= 1'b1;
                  idx_q  <= '0;
               end
            end
            default: begin
               if (cnt_q == '0) st_q <= TS_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
               if (walk_q) begin
                  if (idx_q == OFS_W'(PAGE_BYTES - 1)) walk_q <= 1'b0;
                  else                                  idx_q  <= idx_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy_o     = (st_q == TS_RUN);
   assign walk_o     = walk_q;
   assign walk_idx_o = idx_q;

endmodule

// File: rtl/pw_mem_array.sv
module pw_mem_array #(
   parameter int unsigned DEPTH  = 512,
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rdata_o <= mem_q[raddr_i];
   end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
   parameter int unsigned PAGES      = 32,
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned TWC_CYCLES = 250000,
   localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
   localparam int unsigned PG_W      = (PAGES < 2) ? 1 : $clog2(PAGES),
   localparam int unsigned ADDR_W    = PG_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              byte_stb_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              bit_pend_i,
   input  logic              stop_i,
   input  logic              restart_i,
   input  logic              wp_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ack_o,
   output logic              busy_o
);

   localparam int unsigned DEPTH = (1 << PG_W) * PAGE_BYTES;

   if ((PAGE_BYTES < 2) || ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (TWC_CYCLES < PAGE_BYTES) begin : g_chk_twc
      $error("TWC_CYCLES must cover the page commit walk");
   end

   logic              go;
   logic              walk;
   logic [OFS_W-1:0]  walk_idx;
   logic [DATA_W-1:0] slot_data;
   logic              slot_vld;
   logic [PG_W-1:0]   page;
   logic              mem_we;

   pw_page_buffer #(
      .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .OFS_W(OFS_W), .PG_W(PG_W)
   ) i_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_i     (busy_o),
      .load_i     (load_i),
      .load_pg_i  (load_addr_i[ADDR_W-1:OFS_W]),
      .load_ofs_i (load_addr_i[OFS_W-1:0]),
      .byte_stb_i (byte_stb_i),
      .byte_i     (byte_i),
      .bit_pend_i (bit_pend_i),
      .stop_i     (stop_i),
      .restart_i  (restart_i),
      .wp_i       (wp_i),
      .sel_i      (walk_idx),
      .slot_o     (slot_data),
      .slot_vld_o (slot_vld),
      .page_o     (page),
      .go_o       (go),
      .ack_o      (ack_o)
   );

   pw_write_timer #(
      .TWC_CYCLES(TWC_CYCLES), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)
   ) i_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go),
      .busy_o     (busy_o),
      .walk_o     (walk),
      .walk_idx_o (walk_idx)
   );

   assign mem_we = walk && slot_vld;

   pw_mem_array #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) i_mem (
      .clk     (clk),
      .we_i    (mem_we),
      .waddr_i ({page, walk_idx}),
      .wdata_i (slot_data),
      .raddr_i (rd_addr_i),
      .rdata_o (rd_data_o)
   );

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
   parameter int unsigned TWC_CYCLES = 250000
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic ack_o,
   input logic byte_stb_i,
   input logic stop_i,
   input logic restart_i,
   input logic wp_i,
   input logic mem_we
);

   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= 0;
      else if (busy_o) run_q <= run_q + 1;
      else             run_q <= 0;
   end

   AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy_o); // R3
   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_q == TWC_CYCLES)); // R5
   AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !ack_o); // R5
   AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && wp_i && !busy_o) |=> !busy_o); // R6
   AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (restart_i && !busy_o) |=> !busy_o); // R7
   AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(byte_stb_i)); // R9

endmodule

bind eeprom_page_writer pw_checker #(.TWC_CYCLES(TWC_CYCLES)) i_pw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .ack_o      (ack_o),
   .byte_stb_i (byte_stb_i),
   .stop_i     (stop_i),
   .restart_i  (restart_i),
   .wp_i       (wp_i),
   .mem_we     (mem_we)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;

   localparam int TWC = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [8:0] load_addr_i = '0;
   logic       byte_stb_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       bit_pend_i = 1'b0;
   logic       stop_i = 1'b0;
   logic       restart_i = 1'b0;
   logic       wp_i = 1'b0;
   logic [8:0] rd_addr_i = '0;
   logic [7:0] rd_data_o;
   logic       ack_o;
   logic       busy_o;

   int   nvec = 0;
   int   nfail = 0;
   bit   done = 1'b0;
   logic [7:0] pg [16];
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #10 clk = ~clk;

   eeprom_page_writer #(.TWC_CYCLES(TWC)) i_eeprom_page_writer (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares read data against the expected queue
   always @(posedge clk) begin
      if (exp_q.size() > 0) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         #5;
         check(rd_data_o === e, t, rd_data_o, e);
      end
   end

   task automatic rd_push(input logic [8:0] a, input logic [7:0] e, input string t);
      rd_addr_i = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
   endtask

   task automatic rd_page(input string t);
      for (int k = 0; k < 16; k++) rd_push(9'h030 + 9'(k), pg[k], t);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_load(input logic [8:0] a);
      load_i = 1'b1; load_addr_i = a;
      @(negedge clk);
      load_i = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] d, input bit exp_ack, input string t);
      byte_stb_i = 1'b1; byte_i = d;
      @(negedge clk);
      byte_stb_i = 1'b0;
      check(ack_o == exp_ack, t, ack_o, exp_ack);
   endtask

   task automatic do_stop(input bit pend, input bit exp_busy, input string t);
      stop_i = 1'b1; bit_pend_i = pend;
      @(negedge clk);
      stop_i = 1'b0; bit_pend_i = 1'b0;
      check(busy_o == exp_busy, t, busy_o, exp_busy);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy_o && n < 10 * TWC) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         nfail++; nvec++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy_o == 1'b0, "R1 busy", busy_o, 0);
      check(ack_o == 1'b0, "R1 ack", ack_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // full page 3, R2 and R5 timing
      do_load(9'h030);
      for (int k = 0; k < 16; k++) begin
         pg[k] = 8'(k * 3 + 1);
         do_byte(pg[k], 1'b1, "R9 ack");
      end
      do_stop(1'b0, 1'b1, "R5 busy rise");
      wait_idle(n);
      check(n == TWC, "R5 busy length", n, TWC);
      rd_page("R2 full page");

      // partial write near page end wraps, R2 R3
      do_load(9'h03E);
      do_byte(8'hA0, 1'b1, "R9 ack");
      do_byte(8'hA1, 1'b1, "R9 ack");
      do_byte(8'hA2, 1'b1, "R9 ack");
      do_byte(8'hA3, 1'b1, "R9 ack");
      pg[14] = 8'hA0; pg[15] = 8'hA1; pg[0] = 8'hA2; pg[1] = 8'hA3;
      do_stop(1'b0, 1'b1, "R4 commit");
      wait_idle(n);
      rd_page("R3 partial wrap");

      // seventeen bytes: last overwrites first, R2
      do_load(9'h035);
      for (int k = 0; k < 17; k++) begin
         pg[(5 + k) % 16] = 8'(8'h80 + k);
         do_byte(8'(8'h80 + k), 1'b1, "R9 ack");
      end
      do_stop(1'b0, 1'b1, "R4 commit");
      wait_idle(n);
      check(pg[5] == 8'h90, "R2 overwrite model", pg[5], 8'h90);
      rd_page("R2 overwrite");

      // write protect, R6 and R8
      wp_i = 1'b1;
      do_load(9'h030);
      do_byte(8'h55, 1'b1, "R6 ack under wp");
      do_byte(8'h56, 1'b1, "R6 ack under wp");
      do_stop(1'b0, 1'b0, "R6 no busy");
      rd_page("R8 read under wp");
      wp_i = 1'b0;

      // restart discards, R7
      do_load(9'h030);
      do_byte(8'h66, 1'b1, "R9 ack");
      restart_i = 1'b1;
      @(negedge clk);
      restart_i = 1'b0;
      do_stop(1'b0, 1'b0, "R7 no busy after restart");

      // stop with byte in flight, stop with no data, R4
      do_load(9'h030);
      do_byte(8'h67, 1'b1, "R9 ack");
      do_stop(1'b1, 1'b0, "R4 pending bits");
      do_load(9'h030);
      do_stop(1'b0, 1'b0, "R4 no data");
      rd_page("R7 page unchanged");

      // lockout during busy, R5
      do_load(9'h032);
      do_byte(8'h11, 1'b1, "R9 ack");
      pg[2] = 8'h11;
      do_stop(1'b0, 1'b1, "R4 commit");
      do_load(9'h039);
      do_byte(8'h99, 1'b0, "R5 no ack in busy");
      do_stop(1'b0, 1'b1, "R5 still busy");
      wait_idle(n);
      check(n == TWC - 3, "R5 busy length with traffic", n, TWC - 3);
      @(negedge clk);
      check(busy_o == 1'b0, "R5 no second cycle", busy_o, 0);
      // byte and stop with no load, R4
      do_byte(8'h77, 1'b0, "R4 byte without load");
      do_stop(1'b0, 1'b0, "R4 stop without load");
      rd_page("R5 lockout page");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule